// File: doc/BRIEF.md
# Two-Channel DMA Request Arbiter

This block turns edges on two external request pins into pending DMA requests and decides who owns a shared bus: the CPU, channel 0 or channel 1. Each pin is brought into the clock domain through a synchroniser. A per-channel edge select picks whether a rising or a falling edge counts as a request. A detected edge latches a pending bit for that channel. The pending bit stays set until the channel is granted, even while the channel is disabled.

Grants are taken only when the CPU finishes a bus access, which is signalled by `cpu_done`. At that point the lowest-numbered channel that is both pending and enabled wins. Its pending bit is cleared at the edge where the grant begins, and a one-cycle start strobe is issued for it. The channel keeps the bus until `xfer_done`. Ownership then returns to the CPU, which must complete one more access before any channel is granted again. Address generation, counting and the data path sit outside this block.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, and during reset, `bus_owner` is 0 (CPU), `xfer_start` is all zero and no request is pending; a request latched before a reset is lost.
- R2: With `edge_rise[i]`=1 a rising edge on `irq_pin[i]` makes channel i pending; with `edge_rise[i]`=0 a falling edge does; the opposite edge is ignored. A pin change driven before clock edge k is first grantable by a `cpu_done` sampled at edge k+3.
- R3: A pending bit clears at the same clock edge at which its grant begins; a new pin edge whose set coincides with that clear leaves the bit pending, so the channel is served again.
- R4: When both channels are pending and enabled at a grant decision, channel 0 is granted; `bus_owner` codes are 0 = CPU, 1 = channel 0, 2 = channel 1.
- R5: A granted channel keeps the bus, ignoring `cpu_done`, until `xfer_done` is sampled high; on the next cycle `bus_owner` is 0.
- R6: After any DMA grant ends, no channel is granted until a `cpu_done` is sampled while the CPU owns the bus; one such access suffices for the next pending channel.
- R7: A channel whose `ch_en` bit is low is never granted; its pending bit is kept and the channel is granted at the first `cpu_done` after `ch_en` goes high.
- R8: While the CPU owns the bus and no enabled channel is pending, `cpu_done` and `xfer_done` leave the bus with the CPU.
- R9: `xfer_start[i]` is high for exactly the first cycle in which `bus_owner` shows channel i, and at most one bit of `xfer_start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin | input | NCH | Asynchronous request pins, one per channel |
| edge_rise | input | NCH | Per channel: 1 = rising edge requests, 0 = falling edge requests |
| ch_en | input | NCH | Per-channel enable for grants |
| cpu_done | input | 1 | Pulse: the CPU finished one bus access |
| xfer_done | input | 1 | Pulse: the granted channel finished its transfer |
| bus_owner | output | $clog2(NCH+1) | Bus owner: 0 CPU, i+1 channel i |
| xfer_start | output | NCH | One-cycle strobe at the start of a channel's grant |

## Verification
Both pins rising in the same cycle show that channel 0 wins and that channel 1 waits for a CPU access between the two transfers. Pins that fall in rising mode and rise in falling mode separate the two edge polarities. A request held while its channel is disabled shows that the pending bit is kept and served later. A second pin edge placed so that its set lands on the grant edge separates set-over-clear priority from a plain clear. A reset that arrives while a request is pending shows that the request is dropped.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    // Bus owner code reserved for the processor; channel i uses i+1.
    localparam int unsigned OWNER_CPU = 0;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_kind_e;

endpackage

// File: rtl/dma_pin_edge.sv
module dma_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic pulse
);
    import dma_arb_pkg::*;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } edge_reg_t;

    edge_reg_t cur_q, nxt_d;
    logic      synced;

    assign synced = cur_q.chain[STAGES-1];

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.chain = {cur_q.chain[STAGES-2:0], pin};
        nxt_d.last  = synced;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    always_comb begin
        if (edge_kind_e'(rise_sel) == EDGE_RISE) pulse = synced & ~cur_q.last;
        else                                     pulse = ~synced & cur_q.last;
    end

    // R2: a detected edge is a single-cycle event
    a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && $stable(rise_sel)) |=> !pulse);

endmodule

// File: rtl/dma_req_latch.sv
module dma_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pend
);
    logic pend_q, pend_d;

    always_comb begin
        pend_d = pend_q;
        if (clr) pend_d = 1'b0;
        if (set) pend_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

    // R3: set beats a coincident clear
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> pend);
    // R3: a lone clear drops the request
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !pend);

endmodule

// File: rtl/dma_grant_fsm.sv
module dma_grant_fsm #(
    parameter int NCH = 2,
    localparam int OW = $clog2(NCH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] elig,
    input  logic           cpu_done,
    input  logic           xfer_done,
    output logic [OW-1:0]  owner,
    output logic [NCH-1:0] start,
    output logic [NCH-1:0] clr
);
    import dma_arb_pkg::*;

    localparam logic [OW-1:0] CPU_CODE = OW'(OWNER_CPU);

    typedef struct packed {
        logic [OW-1:0]  owner;
        logic [NCH-1:0] start;
    } fsm_reg_t;

    fsm_reg_t cur_q, nxt_d;
    logic     found;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.start = '0;
        clr         = '0;
        found       = 1'b0;
        if (cur_q.owner == CPU_CODE) begin
            if (cpu_done) begin
                for (int i = 0; i < NCH; i++) begin
                    if (!found && elig[i]) begin
                        found          = 1'b1;
                        nxt_d.owner    = OW'(i + 1);
                        nxt_d.start[i] = 1'b1;
                        clr[i]         = 1'b1;
                    end
                end
            end
        end else if (xfer_done) begin
            nxt_d.owner = CPU_CODE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{owner: CPU_CODE, start: '0};
        else        cur_q <= nxt_d;
    end

    assign owner = cur_q.owner;
    assign start = cur_q.start;

    // R4: channel 0 wins whenever it is eligible at a decision
    a_r4_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == CPU_CODE && cpu_done && elig[0]) |=> (owner == OW'(1)));
    // R5: a DMA grant holds until transfer done
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (owner != CPU_CODE && !xfer_done) |=> $stable(owner));
    // R5: transfer done returns the bus to the CPU
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (owner != CPU_CODE && xfer_done) |=> (owner == CPU_CODE));
    // R6: no direct channel-to-channel handover
    a_r6_cpu_between: assert property (@(posedge clk) disable iff (!rst_n)
        (owner != CPU_CODE) |=> (owner == CPU_CODE || $stable(owner)));
    // R8: the CPU keeps the bus without a cpu_done
    a_r8_cpu_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == CPU_CODE && !cpu_done) |=> (owner == CPU_CODE));
    // R9: at most one start strobe, never two cycles running
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start));
    a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
        (start != '0) |=> (start == '0));

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2,
    localparam int OW         = $clog2(NCH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] irq_pin,
    input  logic [NCH-1:0] edge_rise,
    input  logic [NCH-1:0] ch_en,
    input  logic           cpu_done,
    input  logic           xfer_done,
    output logic [OW-1:0]  bus_owner,
    output logic [NCH-1:0] xfer_start
);
    logic [NCH-1:0] set_pulse;
    logic [NCH-1:0] pend;
    logic [NCH-1:0] clr;
    logic [NCH-1:0] elig;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dma_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (irq_pin[g]),
            .rise_sel (edge_rise[g]),
            .pulse    (set_pulse[g])
        );

        dma_req_latch u_req (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_pulse[g]),
            .clr   (clr[g]),
            .pend  (pend[g])
        );

        // R7: a disabled channel's strobe never fires
        a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_start[g] |-> $past(ch_en[g]));
    end

    assign elig = pend & ch_en;

    dma_grant_fsm #(.NCH(NCH)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (elig),
        .cpu_done  (cpu_done),
        .xfer_done (xfer_done),
        .owner     (bus_owner),
        .start     (xfer_start),
        .clr       (clr)
    );

endmodule

// File: tb/dma_req_arbiter_test.sv
module dma_req_arbiter_test;
    localparam int PERIOD = 10;
    localparam int NV     = 34;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] irq_pin = '0;
    logic [1:0] edge_rise = 2'b11;
    logic [1:0] ch_en = 2'b11;
    logic       cpu_done = 1'b0;
    logic       xfer_done = 1'b0;
    logic [1:0] bus_owner;
    logic [1:0] xfer_start;

    int n_chk = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    dma_req_arbiter uut (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .edge_rise(edge_rise),
        .ch_en(ch_en), .cpu_done(cpu_done), .xfer_done(xfer_done),
        .bus_owner(bus_owner), .xfer_start(xfer_start)
    );

    // {pins, enables, cpu_done, xfer_done, expected owner, expected start, requirement}
    localparam logic [13:0] VEC [NV] = '{
        {2'b00, 2'b11, 1'b0, 1'b0, 2'd0, 2'b00, 4'd1}, // 0  R1 idle
        {2'b11, 2'b11, 1'b0, 1'b0, 2'd0, 2'b00, 4'd2}, // 1  both pins rise
        {2'b11, 2'b11, 1'b0, 1'b0, 2'd0, 2'b00, 4'd2}, // 2
        {2'b11, 2'b11, 1'b1, 1'b0, 2'd0, 2'b00, 4'd2}, // 3  R2 too early
        {2'b11, 2'b11, 1'b1, 1'b0, 2'd1, 2'b01, 4'd4}, // 4  R4 ch0 first
        {2'b11, 2'b11, 1'b1, 1'b0, 2'd1, 2'b00, 4'd5}, // 5  R5 cpu_done ignored
        {2'b11, 2'b11, 1'b0, 1'b1, 2'd0, 2'b00, 4'd5}, // 6  R5 release
        {2'b11, 2'b11, 1'b0, 1'b0, 2'd0, 2'b00, 4'd6}, // 7  R6 cpu holds
        {2'b11, 2'b11, 1'b1, 1'b0, 2'd2, 2'b10, 4'd6}, // 8  R6 ch1 next
        {2'b11, 2'b11, 1'b0, 1'b0, 2'd2, 2'b00, 4'd9}, // 9  R9 strobe one cycle
        {2'b11, 2'b11, 1'b0, 1'b1, 2'd0, 2'b00, 4'd5}, // 10
        {2'b11, 2'b11, 1'b1, 1'b0, 2'd0, 2'b00, 4'd8}, // 11 R8 nothing pending
        {2'b00, 2'b11, 1'b0, 1'b0, 2'd0, 2'b00, 4'd2}, // 12 falling in rise mode
        {2'b00, 2'b11, 1'b0, 1'b0, 2'd0, 2'b00, 4'd2}, // 13
        {2'b00, 2'b11, 1'b0, 1'b0, 2'd0, 2'b00, 4'd2}, // 14
        {2'b00, 2'b11, 1'b1, 1'b0, 2'd0, 2'b00, 4'd2}, // 15 R2 ignored edge
        {2'b01, 2'b10, 1'b0, 1'b0, 2'd0, 2'b00, 4'd7}, // 16 ch0 disabled
        {2'b01, 2'b10, 1'b0, 1'b0, 2'd0, 2'b00, 4'd7}, // 17
        {2'b01, 2'b10, 1'b0, 1'b0, 2'd0, 2'b00, 4'd7}, // 18
        {2'b01, 2'b10, 1'b1, 1'b0, 2'd0, 2'b00, 4'd7}, // 19 R7 no grant
        {2'b01, 2'b11, 1'b0, 1'b0, 2'd0, 2'b00, 4'd7}, // 20 enable
        {2'b01, 2'b11, 1'b1, 1'b0, 2'd1, 2'b01, 4'd7}, // 21 R7 served
        {2'b01, 2'b11, 1'b0, 1'b1, 2'd0, 2'b00, 4'd5}, // 22
        {2'b00, 2'b11, 1'b0, 1'b0, 2'd0, 2'b00, 4'd3}, // 23
        {2'b01, 2'b11, 1'b0, 1'b0, 2'd0, 2'b00, 4'd3}, // 24 short pulse
        {2'b00, 2'b11, 1'b0, 1'b0, 2'd0, 2'b00, 4'd3}, // 25
        {2'b00, 2'b11, 1'b0, 1'b0, 2'd0, 2'b00, 4'd3}, // 26
        {2'b01, 2'b11, 1'b0, 1'b0, 2'd0, 2'b00, 4'd3}, // 27 edge lands on grant
        {2'b01, 2'b11, 1'b0, 1'b0, 2'd0, 2'b00, 4'd3}, // 28
        {2'b01, 2'b11, 1'b1, 1'b0, 2'd1, 2'b01, 4'd3}, // 29 R3 grant + set
        {2'b01, 2'b11, 1'b0, 1'b1, 2'd0, 2'b00, 4'd3}, // 30
        {2'b01, 2'b11, 1'b1, 1'b0, 2'd1, 2'b01, 4'd3}, // 31 R3 served again
        {2'b01, 2'b11, 1'b0, 1'b1, 2'd0, 2'b00, 4'd3}, // 32
        {2'b01, 2'b11, 1'b1, 1'b0, 2'd0, 2'b00, 4'd3}  // 33 R3 cleared after
    };

    task automatic step(input logic [1:0] p, input logic [1:0] en,
                        input logic cd, input logic xd);
        irq_pin   = p;
        ch_en     = en;
        cpu_done  = cd;
        xfer_done = xd;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic [1:0] eo, input logic [1:0] es, input string tag);
        n_chk++;
        if (bus_owner !== eo || xfer_start !== es) begin
            n_bad++;
            $display("FAIL %s: owner=%0d start=%b, expected owner=%0d start=%b",
                     tag, bus_owner, xfer_start, eo, es);
        end
    endtask

    initial begin
        #(PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(2'd0, 2'b00, "R1 in reset");
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(2'd0, 2'b00, "R1 after reset");

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][13:12], VEC[i][11:10], VEC[i][9], VEC[i][8]);
            check(VEC[i][7:6], VEC[i][5:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
        end

        // R2: channel 1 in falling mode ignores a rise, takes a fall
        edge_rise = 2'b01;
        for (int k = 0; k < 4; k++) begin
            step(2'b11, 2'b11, 1'b1, 1'b0);
            check(2'd0, 2'b00, "R2 rise ignored in fall mode");
        end
        step(2'b01, 2'b11, 1'b0, 1'b0);
        step(2'b01, 2'b11, 1'b0, 1'b0);
        step(2'b01, 2'b11, 1'b0, 1'b0);
        step(2'b01, 2'b11, 1'b1, 1'b0);
        check(2'd2, 2'b10, "R2 fall grants ch1");
        // R5: grant holds through cpu_done without xfer_done
        for (int k = 0; k < 4; k++) begin
            step(2'b01, 2'b11, 1'b1, 1'b0);
            check(2'd2, 2'b00, "R5 grant held");
        end
        step(2'b01, 2'b11, 1'b0, 1'b1);
        check(2'd0, 2'b00, "R5 released");
        // R8: xfer_done while CPU owns the bus has no effect
        step(2'b01, 2'b11, 1'b0, 1'b1);
        check(2'd0, 2'b00, "R8 stray xfer_done");

        // R1: a request latched before reset is lost
        edge_rise = 2'b11;
        step(2'b00, 2'b11, 1'b0, 1'b0);
        step(2'b00, 2'b11, 1'b0, 1'b0);
        step(2'b01, 2'b11, 1'b0, 1'b0);
        step(2'b01, 2'b11, 1'b0, 1'b0);
        step(2'b01, 2'b11, 1'b0, 1'b0);
        step(2'b01, 2'b11, 1'b0, 1'b0);
        irq_pin = 2'b00;
        rst_n   = 1'b0;
        @(posedge clk);
        #1;
        check(2'd0, 2'b00, "R1 reset mid-run");
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step(2'b00, 2'b11, 1'b1, 1'b0);
            check(2'd0, 2'b00, "R1 pending dropped by reset");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule